// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block turns the module clock into the two timing strobes a serial port needs. One pulse paces the receiver's oversampling. The other pulse paces the transmitter's bit cells. A single 8-bit control register programs both strobes. That register sits on a simple bus with an address, a write strobe, write data and combinational read data.

The bit rate comes from a chain of dividers. First there is a fixed divide-by-4. After it comes a prescaler, whose divisor is picked by a 2-bit code from the irregular set 1, 3, 4 and 13. Next is a binary stage that divides by a power of two from 1 to 128. The output of that stage is the receiver sample pulse. A further divide-by-16 of that pulse gives the transmitter bit pulse. Any write to the register restarts every divider. The first pulse after a change therefore comes one complete new period later.

The register answers at one fixed address. The companion data register of the serial port sits at the address just below it, and that data register is not part of this block.

Top module: `baud_gen`

## Requirements
- R1: After reset, the register reads 0x00, both fields are zero, and rx_tick pulses once every 4 clocks.
- R2: At address REG_ADDR (default 0x3E), a write loads the prescaler code from wdata bits 5:4 and the rate code from bits 2:0. A read returns these fields at the same positions. Bits 7, 6 and 3 always read 0, and writes to them are ignored.
- R3: A write to any other address changes neither the register nor the tick timing. A read of any other address returns 0x00.
- R4: The prescaler code selects a divisor: 00 selects 1, 01 selects 3, 10 selects 4 and 11 selects 13.
- R5: rx_tick repeats every 4 × prescaler divisor × 2^rate clocks.
- R6: tx_tick is high exactly on every 16th rx_tick, and always in the same cycle as that rx_tick.
- R7: A write to the register is taken at the clock edge that ends the write cycle. At that edge all dividers clear, even when the written value is unchanged. The next rx_tick then falls in the Nth cycle after the write cycle, where N is the new period. The next tx_tick falls in the 16·Nth cycle after the write cycle.
- R8: Each rx_tick and tx_tick is a pulse one clock wide.
- R9: A tick that falls in the same cycle as a register write is still emitted in that cycle. The restart of R7 then applies from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on bus_addr) |
| rx_tick | output | 1 | Receiver sample pulse, 16 per bit |
| tx_tick | output | 1 | Transmitter bit pulse |

## Verification
A register write and a tick can land in the same cycle. In that case the outgoing tick must still appear, and the restart must take effect at the same edge. The bench provokes this case on purpose. It follows the expected divider phase and issues a write in exactly the cycle where a receiver tick is due. It then judges the outcome cycle by cycle: the tick must be present in the write cycle, and the next tick must come one full new period later. Random writes to the register and to other addresses, issued at arbitrary phases, produce further overlaps. Each of them is scored against the same cycle-exact model.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

   // field layout inside the control register (a software-visible contract)
   localparam int CFG_W      = 8;
   localparam int PS_SEL_W   = 2;
   localparam int PS_LSB     = 4;
   localparam int RATE_SEL_W = 3;
   localparam int RATE_LSB   = 0;

   // largest prescaler divisor and the width needed to hold it
   localparam int PS_MAX_DIV = 13;
   localparam int PS_DIV_W   = $clog2(PS_MAX_DIV + 1);

   typedef struct packed {
      logic [PS_SEL_W-1:0]   ps_sel;
      logic [RATE_SEL_W-1:0] rate_sel;
   } baud_cfg_t;

   // irregular prescaler divisor set
   function automatic logic [PS_DIV_W-1:0] ps_divisor(input logic [PS_SEL_W-1:0] code);
      logic [PS_DIV_W-1:0] d;
      case (code)
         2'd0:    d = PS_DIV_W'(1);
         2'd1:    d = PS_DIV_W'(3);
         2'd2:    d = PS_DIV_W'(4);
         default: d = PS_DIV_W'(13);
      endcase
      return d;
   endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
   import baud_gen_pkg::*;
#(
   parameter int                 ADDR_W   = 8,
   parameter logic [ADDR_W-1:0]  REG_ADDR = 8'h3E
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [CFG_W-1:0]  bus_wdata,
   output logic [CFG_W-1:0]  bus_rdata,
   output baud_cfg_t         cfg,
   output logic              restart
);

   logic hit;
   logic unused_rsvd;

   assign hit         = (bus_addr == REG_ADDR);
   assign restart     = hit && bus_we;
   assign unused_rsvd = ^{bus_wdata[7:6], bus_wdata[3]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (restart) begin
         cfg.ps_sel   <= bus_wdata[PS_LSB +: PS_SEL_W];
         cfg.rate_sel <= bus_wdata[RATE_LSB +: RATE_SEL_W];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         bus_rdata[PS_LSB +: PS_SEL_W]     = cfg.ps_sel;
         bus_rdata[RATE_LSB +: RATE_SEL_W] = cfg.rate_sel;
      end
   end

endmodule

// File: rtl/baud_ctr_stage.sv
// Enable-driven modulo counter with a run-time divisor (1..MAX_DIV).
module baud_ctr_stage #(
   parameter int MAX_DIV = 16,
   localparam int DIV_W  = $clog2(MAX_DIV + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   if (MAX_DIV < 1) begin : g_bad_max
      $error("baud_ctr_stage: MAX_DIV must be at least 1");
   end

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] last;
   logic             wrap;

   assign last = div - DIV_W'(1);
   assign wrap = (cnt == last);
   assign tick = en && wrap;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (en)     cnt <= wrap ? '0 : cnt + DIV_W'(1);
   end

endmodule

// File: rtl/baud_rate_stage.sv
// Binary divider by 2**sel: a free-running counter whose low sel bits
// are compared against all ones, so no divisor subtraction is needed.
module baud_rate_stage #(
   parameter int SEL_W  = 3,
   localparam int CNT_W = (1 << SEL_W) - 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
      $error("baud_rate_stage: SEL_W must be 1..5");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;

   assign mask = ~({CNT_W{1'b1}} << sel);
   assign tick = en && ((cnt & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (en)     cnt <= cnt + CNT_W'(1);
   end

endmodule

// File: rtl/baud_gen.sv
module baud_gen
   import baud_gen_pkg::*;
#(
   parameter int                ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR   = 8'h3E,
   parameter int                PRE_DIV    = 4,
   parameter int                OVERSAMPLE = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              rx_tick,
   output logic              tx_tick
);

   localparam int PRE_DW = $clog2(PRE_DIV + 1);
   localparam int OS_DW  = $clog2(OVERSAMPLE + 1);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("baud_gen: ADDR_W must be positive");
   end
   if (REG_ADDR == '0) begin : g_bad_reg
      $error("baud_gen: REG_ADDR needs a data register address below it");
   end
   if (PRE_DIV < 1) begin : g_bad_pre
      $error("baud_gen: PRE_DIV must be at least 1");
   end
   if (OVERSAMPLE < 2) begin : g_bad_os
      $error("baud_gen: OVERSAMPLE must be at least 2");
   end

   baud_cfg_t           cfg;
   logic                restart;
   logic [1:0]          ps_sel;
   logic [2:0]          rate_sel;
   logic [PS_DIV_W-1:0] ps_div;
   logic                pre_tick;
   logic                ps_tick;

   assign ps_sel   = cfg.ps_sel;
   assign rate_sel = cfg.rate_sel;
   assign ps_div   = ps_divisor(cfg.ps_sel);

   baud_cfg_reg #(
      .ADDR_W   (ADDR_W),
      .REG_ADDR (REG_ADDR)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cfg       (cfg),
      .restart   (restart)
   );

   // fixed front divider; vanishes when PRE_DIV is 1
   if (PRE_DIV == 1) begin : g_pre_bypass
      assign pre_tick = 1'b1;
   end else begin : g_pre_div
      baud_ctr_stage #(.MAX_DIV(PRE_DIV)) u_pre (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (restart),
         .en    (1'b1),
         .div   (PRE_DW'(PRE_DIV)),
         .tick  (pre_tick)
      );
   end

   baud_ctr_stage #(.MAX_DIV(PS_MAX_DIV)) u_ps (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .en    (pre_tick),
      .div   (ps_div),
      .tick  (ps_tick)
   );

   baud_rate_stage #(.SEL_W(RATE_SEL_W)) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .en    (ps_tick),
      .sel   (cfg.rate_sel),
      .tick  (rx_tick)
   );

   baud_ctr_stage #(.MAX_DIV(OVERSAMPLE)) u_os (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .en    (rx_tick),
      .div   (OS_DW'(OVERSAMPLE)),
      .tick  (tx_tick)
   );

endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk
   import baud_gen_pkg::*;
#(
   parameter int                ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR   = 8'h3E,
   parameter int                PRE_DIV    = 4,
   parameter int                OVERSAMPLE = 16
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [7:0]        bus_rdata,
   input logic              rx_tick,
   input logic              tx_tick,
   input logic [1:0]        ps_sel,
   input logic [2:0]        rate_sel
);

   logic        wr_hit;
   logic [31:0] gap;
   logic [31:0] rx_seen;
   logic [31:0] period;

   assign wr_hit = bus_we && (bus_addr == REG_ADDR);
   assign period = 32'(PRE_DIV) * 32'(ps_divisor(ps_sel)) * (32'd1 << rate_sel);

   always_ff @(posedge clk) begin
      if (!rst_n || wr_hit) begin
         gap     <= '0;
         rx_seen <= '0;
      end else begin
         gap <= rx_tick ? '0 : gap + 32'd1;
         if (rx_tick)
            rx_seen <= (rx_seen == 32'(OVERSAMPLE - 1)) ? '0 : rx_seen + 32'd1;
      end
   end

   // R5
   period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_tick |-> (gap == period - 32'd1));

   // R6
   tx_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_tick |-> (tx_tick == (rx_seen == 32'(OVERSAMPLE - 1))));

   // R6
   tx_inside_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tick |-> rx_tick);

   // R8
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_tick |=> !rx_tick);

   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & 8'hC8) == 8'h00);

   // R7
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (!tx_tick && (!rx_tick || period == 32'd1)));

   // R3
   foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr != REG_ADDR) |=> ($stable(ps_sel) && $stable(rate_sel)));

endmodule

bind baud_gen baud_gen_chk #(
   .ADDR_W     (ADDR_W),
   .REG_ADDR   (REG_ADDR),
   .PRE_DIV    (PRE_DIV),
   .OVERSAMPLE (OVERSAMPLE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_rdata (bus_rdata),
   .rx_tick   (rx_tick),
   .tx_tick   (tx_tick),
   .ps_sel    (ps_sel),
   .rate_sel  (rate_sel)
);

// File: tb/baud_gen_tb.sv
`timescale 1ns/1ps
module baud_gen_tb;

   localparam logic [7:0] REG = 8'h3E;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = REG;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       rx_tick, tx_tick;

   int          checks = 0;
   int          fails  = 0;
   bit          mon_en = 1'b0;
   int unsigned c = 0;
   logic [7:0]  m_reg = 8'h00;

   always #10 clk = ~clk;   // 50 MHz

   baud_gen u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_tick(rx_tick), .tx_tick(tx_tick)
   );

   // R4: divisor set taken from the requirement
   function automatic int unsigned pd(input logic [1:0] code);
      case (code)
         2'd0: return 1;
         2'd1: return 3;
         2'd2: return 4;
         default: return 13;
      endcase
   endfunction

   // R5: period in clocks
   function automatic int unsigned period(input logic [7:0] r);
      return 4 * pd(r[5:4]) * (1 << r[2:0]);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-exact expectation: cycles since the last restart
   always @(posedge clk) begin
      if (!rst_n) begin
         c     <= 0;
         m_reg <= 8'h00;
      end else if (bus_we && bus_addr == REG) begin
         c     <= 0;
         m_reg <= bus_wdata & 8'h37;
      end else begin
         c <= c + 1;
      end
   end

   always @(negedge clk) begin
      if (mon_en) begin
         int unsigned n;
         bit er, et;
         n  = period(m_reg);
         er = (c % n) == n - 1;
         et = (c % (16 * n)) == 16 * n - 1;
         check(rx_tick == er, "R5/R7/R8 rx_tick", rx_tick, er);
         check(tx_tick == et, "R6/R7 tx_tick", tx_tick, et);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #2;
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(posedge clk); #2;
      bus_we = 1'b0; bus_addr = REG;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
      @(posedge clk); #2;
      bus_addr = a;
      @(negedge clk);
      check(bus_rdata == exp, tag, bus_rdata, exp);
      bus_addr = REG;
   endtask

   task automatic run(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      mon_en = 1'b1;

      // R1: reset state and default cadence
      rd(REG, 8'h00, "R1 reset readback");
      run(140);

      // R2: reserved bits masked, slowest setting runs to its first tick
      wr(REG, 8'hFF);
      rd(REG, 8'h37, "R2 reserved bits read 0");
      run(6700);

      // R3: other addresses
      wr(REG - 8'd1, 8'h00);
      rd(REG, 8'h37, "R3 foreign write ignored");
      rd(REG - 8'd1, 8'h00, "R3 foreign read zero");

      // R4: each prescaler code, rate 1
      for (int k = 0; k < 4; k++) begin
         logic [7:0] v;
         v = 8'(k << 4);
         wr(REG, v);
         rd(REG, v, "R4 prescaler code readback");
         run(16 * period(v) + 8);
      end

      // R7: rewriting the same value restarts
      wr(REG, 8'h11);
      run(9);
      wr(REG, 8'h11);
      run(16 * period(8'h11) + 6);

      // R9: write lands in a tick cycle
      wr(REG, 8'h01);
      for (int k = 0; k < 200; k++) begin
         @(posedge clk); #2;
         if ((c % period(m_reg)) == period(m_reg) - 1) begin
            bus_addr = REG; bus_we = 1'b1; bus_wdata = 8'h02;
            @(negedge clk);
            check(rx_tick == 1'b1, "R9 tick kept in write cycle", rx_tick, 1);
            @(posedge clk); #2;
            bus_we = 1'b0;
            break;
         end
      end
      run(16 * period(8'h02) + 6);

      // random settings and foreign writes at random phases
      for (int k = 0; k < 20; k++) begin
         logic [7:0] v;
         int lim;
         v = 8'($urandom);
         v[2:0] = 3'($urandom_range(2, 0));
         wr(REG, v);
         rd(REG, v & 8'h37, "R2 random readback");
         lim = 16 * period(v) + 10;
         if (lim > 3500) lim = 3500;
         run($urandom_range(lim / 2, 1));
         if ($urandom_range(1, 0) == 1) begin
            logic [7:0] fa;
            fa = 8'($urandom);
            if (fa == REG) fa = 8'h3D;
            wr(fa, 8'($urandom));
            rd(fa, 8'h00, "R3 random foreign read");
         end
         run(lim / 2);
      end

      mon_en = 1'b0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule